// File: doc/BRIEF.md
# Floating-Point Issue Collision Guard

This block sits at the issue point of a floating-point unit whose operations share internal stage resources over several cycles. Five resources are modelled: an unpack stage (U), a shifter (S), an adder (A), a rounder (R) and a divide stage (D). Each operation class claims a fixed set of resources in each cycle after it issues. Whether two operations collide therefore depends on how many cycles separate them.

The guard keeps a map of future resource use, one bitmap per upcoming cycle. Each clock the map advances by one cycle. The pattern of the presented operation is overlaid on the map. If no cycle has a resource claimed twice, the request is accepted and its pattern is merged into the map. Otherwise stall is raised and the map is left alone. The issuing logic holds a stalled request and presents it again on the next cycle, so its whole pattern lands one cycle later. The arithmetic is not part of this block.

Top module: `fp_issue_guard`

## Requirements
- R1: After reset the map is empty, so the first request presented is accepted and no request is refused because of state from before reset.
- R2: The op code is 2 bits: 0 add, 1 subtract, 2 compare, 3 divide. In a cycle with `req_valid` high, exactly one of `issue_ok` and `stall` is high. With `req_valid` low, both are low.
- R3: Add and subtract claim U in the issue cycle, then S+A, A+R and R+S in the next three cycles. A subtract presented one or two cycles after an accepted add stalls. At three cycles it is accepted.
- R4: Divide claims U, then A, then R, then D for `DIV_LEN` consecutive cycles (default 28). A divide presented one cycle after an accepted add stalls. At two cycles it is accepted.
- R5: Compare claims U, then A, then R. A compare presented one cycle after an accepted add stalls. At two cycles it is accepted.
- R6: Operations whose patterns never overlap at their spacing are accepted back to back. Two compares in consecutive cycles, followed by an add, are all accepted.
- R7: A divide presented 1 to `DIV_LEN`-1 cycles after an accepted divide stalls, because of D. At `DIV_LEN` cycles it is accepted.
- R8: A held request stalls in every cycle in which it would still collide. It is accepted in the first cycle in which it fits, and its pattern counts from that cycle of acceptance.
- R9: A stalled request leaves the map unchanged. After an add, a stalled subtract, and then a compare two cycles after the add, the compare is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the map |
| req_valid | input | 1 | An operation is presented this cycle |
| req_op | input | 2 | Operation class (0 add, 1 sub, 2 cmp, 3 div) |
| issue_ok | output | 1 | Request accepted this cycle (combinational) |
| stall | output | 1 | Request refused this cycle (combinational) |

## Verification
The assertions assume that `req_op` is a defined 2-bit code whenever `req_valid` is high. Their follow-on properties assume that the same request is still present in the cycle after the one named. The stimulus changes inputs only just after a rising edge and always drives a legal op code. Between scenarios it leaves enough idle cycles for the map to drain fully, so that each spacing check starts from an empty map and its expected results can be stated directly from the patterns.

// File: rtl/fpchk_pkg.sv
package fpchk_pkg;
  localparam int NRES  = 5;
  localparam int RES_U = 0;
  localparam int RES_S = 1;
  localparam int RES_A = 2;
  localparam int RES_R = 3;
  localparam int RES_D = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_CMP = 2'd2,
    OP_DIV = 2'd3
  } fp_op_e;

  typedef logic [NRES-1:0] res_vec_t;

  // Resources claimed by an op k cycles after it issues.
  function automatic res_vec_t slot_use(fp_op_e op, int k, int dlen);
    res_vec_t v;
    v = '0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        if (k == 0) v[RES_U] = 1'b1;
        if (k == 1) begin v[RES_S] = 1'b1; v[RES_A] = 1'b1; end
        if (k == 2) begin v[RES_A] = 1'b1; v[RES_R] = 1'b1; end
        if (k == 3) begin v[RES_R] = 1'b1; v[RES_S] = 1'b1; end
      end
      OP_CMP: begin
        if (k == 0) v[RES_U] = 1'b1;
        if (k == 1) v[RES_A] = 1'b1;
        if (k == 2) v[RES_R] = 1'b1;
      end
      OP_DIV: begin
        if (k == 0) v[RES_U] = 1'b1;
        if (k == 1) v[RES_A] = 1'b1;
        if (k == 2) v[RES_R] = 1'b1;
        if (k >= 3 && k < 3 + dlen) v[RES_D] = 1'b1;
      end
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/fpchk_pattern.sv
module fpchk_pattern
  import fpchk_pkg::*;
#(
  parameter int DIV_LEN = 28,
  parameter int DEPTH   = 3 + DIV_LEN
) (
  input  logic [1:0]                  op,
  output logic [DEPTH-1:0][NRES-1:0]  pat
);
  fp_op_e op_e;
  assign op_e = fp_op_e'(op);

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign pat[k] = slot_use(op_e, k, DIV_LEN);
  end
endmodule

// File: rtl/fpchk_conflict.sv
module fpchk_conflict
  import fpchk_pkg::*;
#(
  parameter int DEPTH = 31
) (
  input  logic [DEPTH-1:0][NRES-1:0] pat,
  input  logic [DEPTH-1:0][NRES-1:0] occ,
  output logic [DEPTH-1:0]           hits,
  output logic                       conflict
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign hits[k] = |(pat[k] & occ[k]);
  end
  assign conflict = |hits;
endmodule

// File: rtl/fpchk_occmap.sv
module fpchk_occmap
  import fpchk_pkg::*;
#(
  parameter int DEPTH = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       merge,
  input  logic [DEPTH-1:0][NRES-1:0] pat,
  output logic [DEPTH-1:0][NRES-1:0] occ
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    if (k < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ[k] <= '0;
        else        occ[k] <= occ[k+1] | (merge ? pat[k+1] : '0);
      end
    end else begin : g_last
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ[k] <= '0;
        else        occ[k] <= '0;
      end
    end
  end
endmodule

// File: rtl/fp_issue_guard.sv
module fp_issue_guard
  import fpchk_pkg::*;
#(
  parameter int DIV_LEN = 28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  output logic       issue_ok,
  output logic       stall
);
  localparam int DEPTH = 3 + DIV_LEN;

  logic [DEPTH-1:0][NRES-1:0] req_pat;
  logic [DEPTH-1:0][NRES-1:0] occ_map;
  logic [DEPTH-1:0]           slot_hits;
  logic                       collide;
  res_vec_t                   now_slot;

  fpchk_pattern #(.DIV_LEN(DIV_LEN), .DEPTH(DEPTH)) u_pat (
    .op  (req_op),
    .pat (req_pat)
  );

  fpchk_conflict #(.DEPTH(DEPTH)) u_cmp (
    .pat      (req_pat),
    .occ      (occ_map),
    .hits     (slot_hits),
    .conflict (collide)
  );

  assign issue_ok = req_valid && !collide;
  assign stall    = req_valid && collide;
  assign now_slot = occ_map[0];

  fpchk_occmap #(.DEPTH(DEPTH)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .merge (issue_ok),
    .pat   (req_pat),
    .occ   (occ_map)
  );
endmodule

// File: rtl/fp_issue_guard_chk.sv
module fp_issue_guard_chk
  import fpchk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] op,
  input logic       issue_ok,
  input logic       stall,
  input res_vec_t   now_slot
);
  assert_reset_empty_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (now_slot == '0));

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_ok || stall) == req_valid) && !(issue_ok && stall));

  assert_add_sub_gap1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && op == 2'd0) ##1 (req_valid && op == 2'd1) |-> stall);

  assert_add_div_gap1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && op == 2'd0) ##1 (req_valid && op == 2'd3) |-> stall);

  assert_add_cmp_gap1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && op == 2'd0) ##1 (req_valid && op == 2'd2) |-> stall);

  assert_div_div_gap1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && op == 2'd3) ##1 (req_valid && op == 2'd3) |-> stall);

  assert_merge_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && op == 2'd0) |=> (now_slot[RES_S] && now_slot[RES_A]));
endmodule

bind fp_issue_guard fp_issue_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .op        (req_op),
  .issue_ok  (issue_ok),
  .stall     (stall),
  .now_slot  (now_slot)
);

// File: tb/sim_fp_issue_guard.sv
module sim_fp_issue_guard;
  localparam int DIV_LEN = 28;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic       issue_ok, stall;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 1'b0;

  typedef struct {
    bit    vld;
    bit    acc;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  fp_issue_guard #(.DIV_LEN(DIV_LEN)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .issue_ok  (issue_ok),
    .stall     (stall)
  );

  // Driver: apply one cycle of stimulus and queue its expected outcome.
  task automatic drive(input bit v, input logic [1:0] op, input bit acc, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    req_valid = v;
    req_op    = op;
    e.vld = v; e.acc = v && acc; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 1'b0, tag);
  endtask

  // Monitor: compare outputs mid-cycle against the queued expectation.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      bit   es;
      e  = sb.pop_front();
      es = e.vld && !e.acc;
      total++;
      if (issue_ok !== e.acc || stall !== es) begin
        bad++;
        $display("FAIL %s: issue_ok=%0b stall=%0b expected issue_ok=%0b stall=%0b",
                 e.tag, issue_ok, stall, e.acc, es);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [1:0] ADD = 2'd0, SUB = 2'd1, CMP = 2'd2, DIV = 2'd3;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R2: idle after reset, then first request accepted
    idle(2, "R2 idle no outputs");
    drive(1, DIV, 1, "R1 first after reset");
    idle(DIV_LEN + 8, "R2 drain");

    // R3: add then subtract at gaps 1,2 stall; 3 accepted (held retry, R8)
    drive(1, ADD, 1, "R3 add");
    drive(1, SUB, 0, "R3 sub gap1");
    drive(1, SUB, 0, "R3 sub gap2");
    drive(1, SUB, 1, "R3 sub gap3");
    idle(8, "R2 drain");

    // R3: explicit gap 2 after idle
    drive(1, ADD, 1, "R3 add");
    idle(1, "R2 idle");
    drive(1, SUB, 0, "R3 sub gap2 after idle");
    idle(8, "R2 drain");

    // R4: add then divide
    drive(1, ADD, 1, "R4 add");
    drive(1, DIV, 0, "R4 div gap1");
    drive(1, DIV, 1, "R4 div gap2");
    idle(DIV_LEN + 8, "R2 drain");

    // R5: add then compare
    drive(1, ADD, 1, "R5 add");
    drive(1, CMP, 0, "R5 cmp gap1");
    drive(1, CMP, 1, "R5 cmp gap2");
    idle(8, "R2 drain");

    // R6: back to back non-overlapping
    drive(1, CMP, 1, "R6 cmp a");
    drive(1, CMP, 1, "R6 cmp b");
    drive(1, ADD, 1, "R6 add after cmps");
    idle(8, "R2 drain");

    // R7: divide after divide
    drive(1, DIV, 1, "R7 div first");
    for (int g = 1; g < DIV_LEN; g++) drive(1, DIV, 0, "R7 div within D window");
    drive(1, DIV, 1, "R7 div at DIV_LEN");
    idle(DIV_LEN + 8, "R2 drain");

    // R8: held subtracts, pattern counts from acceptance cycle
    drive(1, ADD, 1, "R8 add");
    drive(1, SUB, 0, "R8 sub hold 1");
    drive(1, SUB, 0, "R8 sub hold 2");
    drive(1, SUB, 1, "R8 sub accept");
    drive(1, SUB, 0, "R8 next sub gap1");
    drive(1, SUB, 0, "R8 next sub gap2");
    drive(1, SUB, 1, "R8 next sub gap3");
    idle(8, "R2 drain");

    // R9: stalled subtract must not occupy the map
    drive(1, ADD, 1, "R9 add");
    drive(1, SUB, 0, "R9 sub stalled");
    drive(1, CMP, 1, "R9 cmp after stalled sub");
    idle(4, "R2 drain");

    @(posedge clk);
    wait (sb.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule